// File: doc/BRIEF.md
# Programmable CIC Decimator

This block lowers the sample rate of a complex baseband stream, an in-phase lane and a quadrature lane, by an integer ratio chosen at run time. Each lane is a five-stage cascaded integrator-comb filter built only from adders, subtractors and registers, with no multipliers. The integrators run on every accepted input sample. The combs run once per decimated sample. The filter is a coarse low-pass. Its passband droop is left to the FIR stage that follows.

A configuration write loads a new ratio. The ratio is clamped into the supported range, and the matching output shift is derived from it. The write also clears all filter history and restarts the sample count. Every decimated output has the accumulator's bit growth removed by an arithmetic right shift of ceil(5·log2 R), so the DC gain R^5 / 2^shift lies in (0.5, 1] for every ratio. The shifted value is rounded half-up and saturated to the output width.

Top module: `cic_decim`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_valid` is 0, and `out_i` and `out_q` are 0.
- R2: With `in_valid` held high, `out_valid` is a single-cycle pulse that repeats every R cycles, where R is the active ratio.
- R3: Only cycles with `in_valid` high advance the decimation. With `in_valid` high on alternate cycles, the pulse period is 2R cycles. With `in_valid` held low, no pulse appears after the ones already in flight, and the outputs hold their values.
- R4: For a constant input x on a lane, the settled output of that lane equals floor((x·R^5 + 2^(s−1)) / 2^s), with s = ceil(5·log2 R). This holds for every ratio between `R_MIN` and `R_MAX`.
- R5: Each output is saturated to the signed range of `OUT_W` bits. At the default output width that range is −131072 to 131071.
- R6: A ratio write clears every integrator, comb and the sample counter. If zero input follows the write, every later output is exactly 0, whatever the earlier data was.
- R7: The sample offered in the same cycle as a ratio write is dropped. With `in_valid` held high, counting the write cycle as cycle 0, the first `out_valid` after the write appears in cycle R+3.
- R8: A written ratio below `R_MIN` takes effect as `R_MIN`, and one above `R_MAX` takes effect as `R_MAX`. The active ratio changes only on a write. After reset it is `R_RESET`.
- R9: The I and Q lanes are filtered independently with the same ratio and shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Ratio write strobe; also clears filter state |
| cfg_ratio | input | clog2(R_MAX+1) | Requested decimation ratio, unsigned |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | IN_W | In-phase input sample, two's complement |
| in_q | input | IN_W | Quadrature input sample, two's complement |
| out_valid | output | 1 | Decimated sample strobe |
| out_i | output | OUT_W | In-phase decimated sample, two's complement |
| out_q | output | OUT_W | Quadrature decimated sample, two's complement |

## Verification
A miscounted modulo counter shows at the ports within one decimation period, as a strobe spacing other than R cycles. A wrong shift or a missing rounding term shows as a DC level that is off by a factor of two or by one LSB, once the roughly ten-output transient has passed. Stale integrator or comb history after a ratio write shows as nonzero outputs during a zero-input run in the first dozen decimated samples. A broken clamp shows as a strobe period of the raw written value instead of the limit.

// File: rtl/cic_pkg.sv
package cic_pkg;

   localparam int unsigned LANES     = 2;
   localparam int unsigned MAX_ORDER = 16;

   // Smallest s with 2^s >= r^n, i.e. ceil(n*log2(r)); r^n must fit in 64 bits.
   function automatic int unsigned shift_for_ratio(input longint unsigned r,
                                                   input int unsigned n);
      longint unsigned p;
      int unsigned s;
      p = 64'd1;
      for (int unsigned i = 0; i < MAX_ORDER; i++) begin
         if (i < n) p = p * r;
      end
      s = 0;
      for (int unsigned b = 0; b < 64; b++) begin
         if ((64'd1 << b) < p) s = s + 1;
      end
      return s;
   endfunction

endpackage

// File: rtl/cic_ratio_ctrl.sv
module cic_ratio_ctrl #(
   parameter int unsigned N       = 5,
   parameter int unsigned R_MIN   = 8,
   parameter int unsigned R_MAX   = 4096,
   parameter int unsigned R_RESET = 25,
   parameter int unsigned RW      = 13,
   parameter int unsigned SW      = 7
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          cfg_we,
   input  logic [RW-1:0] cfg_ratio,
   input  logic          in_valid,
   output logic [RW-1:0] ratio_q,
   output logic [SW-1:0] shift_q,
   output logic          comb_en,
   output logic          scale_en,
   output logic          out_valid
);

   localparam logic [RW-1:0] R_LO   = RW'(R_MIN);
   localparam logic [RW-1:0] R_HI   = RW'(R_MAX);
   localparam logic [RW-1:0] R_RST  = RW'(R_RESET);
   localparam logic [SW-1:0] S_RST  = SW'(cic_pkg::shift_for_ratio(64'(R_RESET), N));

   logic [RW-1:0] ratio_cl;
   logic [SW-1:0] shift_next;
   logic [RW-1:0] cnt_q;
   logic          last_sample;

   always_comb begin
      if (cfg_ratio < R_LO)      ratio_cl = R_LO;
      else if (cfg_ratio > R_HI) ratio_cl = R_HI;
      else                       ratio_cl = cfg_ratio;
   end

   assign shift_next  = SW'(cic_pkg::shift_for_ratio(64'(ratio_cl), N));
   assign last_sample = (cnt_q == ratio_q - RW'(1));

   always_ff @(posedge clk) begin
      if (rst) begin
         ratio_q   <= R_RST;
         shift_q   <= S_RST;
         cnt_q     <= '0;
         comb_en   <= 1'b0;
         scale_en  <= 1'b0;
         out_valid <= 1'b0;
      end else if (cfg_we) begin
         ratio_q   <= ratio_cl;
         shift_q   <= shift_next;
         cnt_q     <= '0;
         comb_en   <= 1'b0;
         scale_en  <= 1'b0;
         out_valid <= 1'b0;
      end else begin
         scale_en  <= comb_en;
         out_valid <= scale_en;
         comb_en   <= 1'b0;
         if (in_valid) begin
            if (last_sample) begin
               cnt_q   <= '0;
               comb_en <= 1'b1;
            end else begin
               cnt_q   <= cnt_q + RW'(1);
            end
         end
      end
   end

endmodule

// File: rtl/cic_integrators.sv
module cic_integrators #(
   parameter int unsigned N     = 5,
   parameter int unsigned IN_W  = 16,
   parameter int unsigned ACC_W = 76
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    clr,
   input  logic                    en,
   input  logic signed [IN_W-1:0]  din,
   output logic signed [ACC_W-1:0] dout
);

   logic signed [ACC_W-1:0] stage_in [N+1];

   assign stage_in[0] = {{(ACC_W-IN_W){din[IN_W-1]}}, din};

   for (genvar k = 0; k < N; k++) begin : g_int
      logic signed [ACC_W-1:0] acc;
      always_ff @(posedge clk) begin
         if (rst || clr)  acc <= '0;
         else if (en)     acc <= acc + stage_in[k];
      end
      assign stage_in[k+1] = acc;
   end

   assign dout = stage_in[N];

endmodule

// File: rtl/cic_combs.sv
module cic_combs #(
   parameter int unsigned N     = 5,
   parameter int unsigned ACC_W = 76
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    clr,
   input  logic                    en,
   input  logic signed [ACC_W-1:0] din,
   output logic signed [ACC_W-1:0] dout
);

   logic signed [ACC_W-1:0] stage_out [N+1];

   assign stage_out[0] = din;

   for (genvar k = 0; k < N; k++) begin : g_comb
      logic signed [ACC_W-1:0] dly;
      logic signed [ACC_W-1:0] res;
      always_ff @(posedge clk) begin
         if (rst || clr) begin
            dly <= '0;
            res <= '0;
         end else if (en) begin
            dly <= stage_out[k];
            res <= stage_out[k] - dly;
         end
      end
      assign stage_out[k+1] = res;
   end

   assign dout = stage_out[N];

endmodule

// File: rtl/cic_scaler.sv
module cic_scaler #(
   parameter int unsigned IN_W  = 16,
   parameter int unsigned ACC_W = 76,
   parameter int unsigned OUT_W = 18,
   parameter int unsigned SW    = 7
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    en,
   input  logic [SW-1:0]           shift,
   input  logic signed [ACC_W-1:0] din,
   output logic signed [OUT_W-1:0] dout
);

   localparam int unsigned EW = ACC_W + 1;
   localparam logic signed [EW-1:0] SAT_HI = {{(EW-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
   localparam logic signed [EW-1:0] SAT_LO = {{(EW-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

   logic signed [EW-1:0] ext;
   logic signed [EW-1:0] half;
   logic signed [EW-1:0] rounded;
   logic signed [EW-1:0] shifted;
   logic signed [OUT_W-1:0] limited;

   assign ext     = {din[ACC_W-1], din};
   assign half    = (shift == '0) ? '0 : (EW'(1) << (shift - SW'(1)));
   assign rounded = ext + half;
   assign shifted = rounded >>> shift;

   if (IN_W >= OUT_W) begin : g_sat
      always_comb begin
         if (shifted > SAT_HI)      limited = SAT_HI[OUT_W-1:0];
         else if (shifted < SAT_LO) limited = SAT_LO[OUT_W-1:0];
         else                       limited = shifted[OUT_W-1:0];
      end
   end else begin : g_nosat
      assign limited = shifted[OUT_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst)     dout <= '0;
      else if (en) dout <= limited;
   end

endmodule

// File: rtl/cic_decim.sv
module cic_decim #(
   parameter int unsigned IN_W     = 16,
   parameter int unsigned OUT_W    = 18,
   parameter int unsigned N_STAGES = 5,
   parameter int unsigned R_MIN    = 8,
   parameter int unsigned R_MAX    = 4096,
   parameter int unsigned R_RESET  = 25,
   localparam int unsigned RW      = $clog2(R_MAX + 1)
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    cfg_we,
   input  logic [RW-1:0]           cfg_ratio,
   input  logic                    in_valid,
   input  logic signed [IN_W-1:0]  in_i,
   input  logic signed [IN_W-1:0]  in_q,
   output logic                    out_valid,
   output logic signed [OUT_W-1:0] out_i,
   output logic signed [OUT_W-1:0] out_q
);

   localparam int unsigned GROWTH = N_STAGES * $clog2(R_MAX);
   localparam int unsigned ACC_W  = IN_W + GROWTH;
   localparam int unsigned SW     = $clog2(ACC_W + 1);

   if (N_STAGES < 1 || N_STAGES > cic_pkg::MAX_ORDER) begin : g_bad_order
      $error("cic_decim: N_STAGES out of supported range");
   end
   if (R_MIN < 2 || R_MAX < R_MIN) begin : g_bad_range
      $error("cic_decim: ratio limits inconsistent");
   end
   if (R_RESET < R_MIN || R_RESET > R_MAX) begin : g_bad_reset
      $error("cic_decim: R_RESET outside ratio limits");
   end
   if (GROWTH > 63) begin : g_bad_growth
      $error("cic_decim: R_MAX^N_STAGES exceeds shift computation width");
   end
   if (IN_W < 2 || OUT_W < 2) begin : g_bad_width
      $error("cic_decim: data widths too small");
   end

   logic [RW-1:0] ratio_q;
   logic [SW-1:0] shift_q;
   logic          comb_en;
   logic          scale_en;

   cic_ratio_ctrl #(
      .N       (N_STAGES),
      .R_MIN   (R_MIN),
      .R_MAX   (R_MAX),
      .R_RESET (R_RESET),
      .RW      (RW),
      .SW      (SW)
   ) u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .cfg_we    (cfg_we),
      .cfg_ratio (cfg_ratio),
      .in_valid  (in_valid),
      .ratio_q   (ratio_q),
      .shift_q   (shift_q),
      .comb_en   (comb_en),
      .scale_en  (scale_en),
      .out_valid (out_valid)
   );

   logic signed [IN_W-1:0]  lane_in  [cic_pkg::LANES];
   logic signed [OUT_W-1:0] lane_out [cic_pkg::LANES];

   assign lane_in[0] = in_i;
   assign lane_in[1] = in_q;

   for (genvar l = 0; l < cic_pkg::LANES; l++) begin : g_lane
      logic signed [ACC_W-1:0] integ_out;
      logic signed [ACC_W-1:0] comb_out;

      cic_integrators #(
         .N     (N_STAGES),
         .IN_W  (IN_W),
         .ACC_W (ACC_W)
      ) u_int (
         .clk  (clk),
         .rst  (rst),
         .clr  (cfg_we),
         .en   (in_valid),
         .din  (lane_in[l]),
         .dout (integ_out)
      );

      cic_combs #(
         .N     (N_STAGES),
         .ACC_W (ACC_W)
      ) u_comb (
         .clk  (clk),
         .rst  (rst),
         .clr  (cfg_we),
         .en   (comb_en),
         .din  (integ_out),
         .dout (comb_out)
      );

      cic_scaler #(
         .IN_W  (IN_W),
         .ACC_W (ACC_W),
         .OUT_W (OUT_W),
         .SW    (SW)
      ) u_scale (
         .clk   (clk),
         .rst   (rst),
         .en    (scale_en),
         .shift (shift_q),
         .din   (comb_out),
         .dout  (lane_out[l])
      );
   end

   assign out_i = lane_out[0];
   assign out_q = lane_out[1];

endmodule

// File: rtl/cic_decim_chk.sv
module cic_decim_chk #(
   parameter int unsigned RW    = 13,
   parameter int unsigned R_MIN = 8,
   parameter int unsigned R_MAX = 4096
) (
   input logic          clk,
   input logic          rst,
   input logic          cfg_we,
   input logic          in_valid,
   input logic          out_valid,
   input logic [RW-1:0] ratio_q
);

   // R1: reset leaves the strobe low in the following cycle
   assert_idle_after_reset_R1: assert property (@(posedge clk)
      rst |=> !out_valid);

   // R2: each strobe lasts exactly one cycle
   assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid);

   // R3: a strobe is always caused by an accepted sample three cycles earlier
   assert_strobe_follows_sample_R3: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(in_valid, 3));

   // R6: a ratio write cancels strobes in flight
   assert_write_quiets_R6: assert property (@(posedge clk) disable iff (rst)
      cfg_we |=> !out_valid);

   // R8: active ratio stays inside the limits
   assert_ratio_in_range_R8: assert property (@(posedge clk) disable iff (rst)
      (ratio_q >= RW'(R_MIN)) && (ratio_q <= RW'(R_MAX)));

   // R8: active ratio only changes on a write
   assert_ratio_holds_R8: assert property (@(posedge clk) disable iff (rst)
      !cfg_we |=> $stable(ratio_q));

endmodule

bind cic_decim cic_decim_chk #(
   .RW    (RW),
   .R_MIN (R_MIN),
   .R_MAX (R_MAX)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .cfg_we    (cfg_we),
   .in_valid  (in_valid),
   .out_valid (out_valid),
   .ratio_q   (ratio_q)
);

// File: tb/sim_cic_decim.sv
`timescale 1ns/1ps
module sim_cic_decim;

   localparam int unsigned IN_W    = 20;
   localparam int unsigned OUT_W   = 18;
   localparam int unsigned NST     = 5;
   localparam int unsigned R_MIN   = 8;
   localparam int unsigned R_MAX   = 64;
   localparam int unsigned R_RESET = 25;
   localparam int unsigned RW      = $clog2(R_MAX + 1);

   logic                    clk = 1'b0;
   logic                    rst = 1'b1;
   logic                    cfg_we = 1'b0;
   logic [RW-1:0]           cfg_ratio = '0;
   logic                    in_valid = 1'b0;
   logic signed [IN_W-1:0]  in_i = '0;
   logic signed [IN_W-1:0]  in_q = '0;
   logic                    out_valid;
   logic signed [OUT_W-1:0] out_i;
   logic signed [OUT_W-1:0] out_q;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   cic_decim #(
      .IN_W     (IN_W),
      .OUT_W    (OUT_W),
      .N_STAGES (NST),
      .R_MIN    (R_MIN),
      .R_MAX    (R_MAX),
      .R_RESET  (R_RESET)
   ) u0 (
      .clk       (clk),
      .rst       (rst),
      .cfg_we    (cfg_we),
      .cfg_ratio (cfg_ratio),
      .in_valid  (in_valid),
      .in_i      (in_i),
      .in_q      (in_q),
      .out_valid (out_valid),
      .out_i     (out_i),
      .out_q     (out_q)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic longint expect_dc(input longint x, input int r);
      longint p;
      longint v;
      longint hi;
      longint lo;
      int s;
      p = 1;
      for (int i = 0; i < int'(NST); i++) p = p * r;
      s = 0;
      while ((64'sd1 <<< s) < p) s++;
      v  = (x * p + (64'sd1 <<< (s - 1))) >>> s;
      hi = (64'sd1 <<< (OUT_W - 1)) - 1;
      lo = -(64'sd1 <<< (OUT_W - 1));
      if (v > hi) v = hi;
      if (v < lo) v = lo;
      return v;
   endfunction

   task automatic write_ratio(input int r);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_ratio = RW'(r);
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   // R4 / R5 / R9: settle on DC input and compare both lanes
   task automatic dc_test(input int r, input longint xi, input longint xq);
      int got;
      int guard;
      longint ai;
      longint aq;
      in_valid = 1'b1;
      in_i = IN_W'(xi);
      in_q = IN_W'(xq);
      write_ratio(r);
      got = 0;
      guard = 0;
      ai = 0;
      aq = 0;
      while (got < 14 && guard < 20 * r + 100) begin
         @(negedge clk);
         guard++;
         if (out_valid) begin
            got++;
            ai = out_i;
            aq = out_q;
         end
      end
      chk("R4 pulses seen", got, 14);
      chk("R4 R9 I lane dc level", ai, expect_dc(xi, r));
      chk("R4 R9 Q lane dc level", aq, expect_dc(xq, r));
   endtask

   // R2 / R3 / R8: cycles between second and third strobe after a write
   task automatic measure_period(input int r, input bit alt, output int period);
      int t;
      int p;
      int t2;
      int t3;
      in_i = '0;
      in_q = '0;
      in_valid = 1'b1;
      write_ratio(r);
      t = 0; p = 0; t2 = 0; t3 = 0;
      while (p < 3 && t < 1000) begin
         if (alt) in_valid = ~in_valid;
         @(negedge clk);
         t++;
         if (out_valid) begin
            p++;
            if (p == 2) t2 = t;
            if (p == 3) t3 = t;
         end
      end
      period = t3 - t2;
      in_valid = 1'b1;
   endtask

   initial begin
      int per;
      int n;
      int nz_i;
      int nz_q;
      int pulses;
      longint held_i;
      bit stable_ok;

      // R1: reset state
      repeat (4) @(negedge clk);
      chk("R1 out_valid in reset", out_valid, 0);
      chk("R1 out_i in reset", out_i, 0);
      chk("R1 out_q in reset", out_q, 0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 out_valid after reset", out_valid, 0);
      chk("R1 out_i after reset", out_i, 0);

      // R2: continuous input, period equals ratio
      measure_period(25, 1'b0, per);
      chk("R2 period r=25", per, 25);
      measure_period(8, 1'b0, per);
      chk("R2 period r=8", per, 8);
      measure_period(64, 1'b0, per);
      chk("R2 period r=64", per, 64);

      // R3: alternate-cycle input doubles the period
      measure_period(10, 1'b1, per);
      chk("R3 period alternating r=10", per, 20);

      // R3: stalled input gives no strobes and held outputs
      in_i = 20'sd4000;
      in_q = -20'sd4000;
      measure_period(10, 1'b0, per);
      in_valid = 1'b0;
      repeat (4) @(negedge clk);
      held_i = out_i;
      pulses = 0;
      stable_ok = 1'b1;
      for (int c = 0; c < 40; c++) begin
         @(negedge clk);
         if (out_valid) pulses++;
         if (longint'(out_i) != held_i) stable_ok = 1'b0;
      end
      chk("R3 no strobe while stalled", pulses, 0);
      chk("R3 output held while stalled", stable_ok, 1);

      // R8: clamping of out-of-range ratios
      measure_period(3, 1'b0, per);
      chk("R8 low clamp", per, 8);
      measure_period(0, 1'b0, per);
      chk("R8 zero clamp", per, 8);
      measure_period(100, 1'b0, per);
      chk("R8 high clamp", per, 64);

      // R7: first strobe latency after a write
      in_i = '0;
      in_q = '0;
      in_valid = 1'b1;
      write_ratio(12);
      n = 1;
      while (!out_valid && n < 200) begin
         @(negedge clk);
         n++;
      end
      chk("R7 first strobe cycle r=12", n, 15);

      // R4 / R9: sweep of every ratio with distinct per-lane DC levels
      for (int r = int'(R_MIN); r <= int'(R_MAX); r++) begin
         longint xi;
         longint xq;
         xi = longint'((r * 7919) % 600000) - 300000;
         xq = -(xi / 3) + r;
         dc_test(r, xi, xq);
      end

      // R4: negative rounding at r=25
      dc_test(25, -100, 100);

      // R5: saturation at both rails
      dc_test(25, 524287, -524288);
      dc_test(64, -524288, 524287);

      // R6 / R7: write with a large sample in the write cycle, zeros after
      in_i = 20'sd500000;
      in_q = -20'sd500000;
      in_valid = 1'b1;
      write_ratio(25);
      in_i = '0;
      in_q = '0;
      pulses = 0; nz_i = 0; nz_q = 0; n = 0;
      while (pulses < 14 && n < 1000) begin
         @(negedge clk);
         n++;
         if (out_valid) begin
            pulses++;
            if (out_i != '0) nz_i++;
            if (out_q != '0) nz_q++;
         end
      end
      chk("R6 R7 cleared I history gives zero", nz_i, 0);
      chk("R6 R7 cleared Q history gives zero", nz_q, 0);
      chk("R6 pulses after clear", pulses, 14);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule